// File: doc/BRIEF.md
# Serial Command Interface and Decoder

This block is the host-facing serial slave of a fluorescent display controller. A host frames each transaction by pulling chip select low, and the serial clock and data lines are cleaned by a double-sample noise filter. The block then assembles bytes least-significant bit first and decodes the first byte of each frame as a command. Three commands update configuration registers: display state, digit start position and port output data.

The fourth command is display data. After it, every further byte in the same frame is written to the display RAM at successive addresses. During such a frame the serial output returns one converter result byte in each data byte slot. Converter results come in on a flat input bus, and scanning the display belongs to a separate block.

Top module: `serial_cmd_dec`

## Requirements
- R1: A frame lasts while `cs_n` is low. Raising `cs_n` ends it, discards any partly received byte, clears display-data mode and sets the RAM address back to 0.
- R2: `sdout_oe` is 1 only while `cs_n` is low, so the output is released whenever chip select is high.
- R3: Bits are captured on the rising edge of the filtered serial clock, bit 0 first and bit 7 last.
- R4: `sclk` and `sdin` are sampled once every `SAMPLE_DIV` system clocks. A new level is accepted only when two successive samples agree, so a pulse shorter than one sample period is ignored.
- R5: The first byte of a frame is decoded on bits 7:5, and all other command bits keep the positions given here:
  - 111 (display data): bit 0 sets `seg_wide`, where 1 means 17 or more segments.
  - 110 (display state): bit 4 sets `disp_on`, bits 3:2 set `digit_cnt` and bits 1:0 set `duty_sel`.
  - 101 (digit start): bits 3:0 set `dig_start`.
  - 100 (port data): bits 3:0 go to `port_hi` when bit 4 is 1 and to `port_lo` when bit 4 is 0.
- R6: After a display-data command, each further byte of the frame is written to the RAM, starting at address 0 and rising by one per byte.
- R7: In a display-data frame, the k-th byte slot after the command returns converter byte k, taken from `ad_bytes[8k+7:8k]`, least-significant bit first. Each output bit changes on a falling edge of the filtered serial clock. The command slot, and every slot from `NUM_AD` onward, drives 0.
- R8: `byte_done` pulses for exactly one system clock for each complete byte received.
- R9: Reset clears all configuration outputs to 0 and holds `ram_we` and `byte_done` low.
- R10: A first byte with bit 7 equal to 0 changes no configuration output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; idles high |
| sdin | input | 1 | Serial data in |
| ad_bytes | input | NUM_AD*8 | Converter result bytes; byte k is at bits 8k+7:8k |
| sdout | output | 1 | Serial data out |
| sdout_oe | output | 1 | Output enable for sdout |
| byte_done | output | 1 | One-cycle strobe when a byte is complete |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | ADDR_W | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |
| disp_on | output | 1 | Display enable |
| digit_cnt | output | 2 | Digit count code |
| duty_sel | output | 2 | Dimmer duty code |
| dig_start | output | 4 | Digit start position code |
| seg_wide | output | 1 | Segment count flag |
| port_lo | output | 4 | Output data for the low port nibble |
| port_hi | output | 4 | Output data for the high port nibble |

## Verification
An input edge reaches the filtered domain 3 to 4 sample periods after it happens, which is about 16 system clocks with the default divider. Each serial half period in the bench is 40 system clocks. The bench reads `sdout` on the last system clock before it raises `sclk`, by which time the falling-edge update has long settled. It reads configuration registers and RAM write records only after chip select has gone high again and a further 80 clocks have passed, well after the last byte strobe.

// File: rtl/serial_cmd_dec.sv
module serial_cmd_dec #(
  parameter int SAMPLE_DIV = 4,
  parameter int NUM_AD     = 6,
  parameter int ADDR_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                sdin,
  input  logic [NUM_AD*8-1:0] ad_bytes,
  output logic                sdout,
  output logic                sdout_oe,
  output logic                byte_done,
  output logic                ram_we,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [7:0]          ram_wdata,
  output logic                disp_on,
  output logic [1:0]          digit_cnt,
  output logic [1:0]          duty_sel,
  output logic [3:0]          dig_start,
  output logic                seg_wide,
  output logic [3:0]          port_lo,
  output logic [3:0]          port_hi
);
  localparam int DIV_W  = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int SLOT_W = $clog2(NUM_AD + 1);

  logic [DIV_W-1:0]  div_cnt;
  logic [1:0]        cs_s, ck_s, di_s;
  logic              ck_prev, di_prev, ck_f, di_f, ck_f_d;
  logic [2:0]        bit_cnt;
  logic [6:0]        shreg;
  logic [7:0]        tx;
  logic              data_mode;
  logic [SLOT_W-1:0] slot;

  wire tick     = (div_cnt == DIV_W'(SAMPLE_DIV - 1));
  wire act      = ~cs_s[1];
  wire rise     = act & ck_f & ~ck_f_d;
  wire fall     = act & ~ck_f & ck_f_d;
  wire [7:0] byte_in   = {di_f, shreg};
  wire [7:0] slot_byte = (slot < SLOT_W'(NUM_AD)) ? ad_bytes[{slot, 3'b000} +: 8] : 8'h00;

  assign sdout    = tx[0];
  assign sdout_oe = ~cs_n;

  // synchronisers and double-sample filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      cs_s    <= 2'b11;
      ck_s    <= 2'b11;
      di_s    <= 2'b00;
      ck_prev <= 1'b1;
      di_prev <= 1'b0;
      ck_f    <= 1'b1;
      di_f    <= 1'b0;
      ck_f_d  <= 1'b1;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
      cs_s    <= {cs_s[0], cs_n};
      ck_s    <= {ck_s[0], sclk};
      di_s    <= {di_s[0], sdin};
      ck_f_d  <= ck_f;
      if (tick) begin
        ck_prev <= ck_s[1];
        di_prev <= di_s[1];
        if (ck_s[1] == ck_prev) ck_f <= ck_s[1];
        if (di_s[1] == di_prev) di_f <= di_s[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      tx        <= '0;
      data_mode <= 1'b0;
      slot      <= '0;
      byte_done <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      disp_on   <= 1'b0;
      digit_cnt <= '0;
      duty_sel  <= '0;
      dig_start <= '0;
      seg_wide  <= 1'b0;
      port_lo   <= '0;
      port_hi   <= '0;
    end else begin
      byte_done <= 1'b0;
      ram_we    <= 1'b0;
      if (!act) begin
        bit_cnt   <= '0;
        shreg     <= '0;
        tx        <= '0;
        data_mode <= 1'b0;
        slot      <= '0;
        ram_addr  <= '0;
      end else begin
        if (ram_we) ram_addr <= ram_addr + ADDR_W'(1);
        if (rise) begin
          shreg   <= byte_in[7:1];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            if (data_mode) begin
              ram_we    <= 1'b1;
              ram_wdata <= byte_in;
            end else begin
              case (byte_in[7:5])
                3'b111: begin seg_wide <= byte_in[0]; data_mode <= 1'b1; end
                3'b110: begin
                  disp_on   <= byte_in[4];
                  digit_cnt <= byte_in[3:2];
                  duty_sel  <= byte_in[1:0];
                end
                3'b101: dig_start <= byte_in[3:0];
                3'b100: if (byte_in[4]) port_hi <= byte_in[3:0];
                        else            port_lo <= byte_in[3:0];
                default: ;
              endcase
            end
          end
        end
        if (fall) begin
          if (bit_cnt == 3'd0) begin
            tx <= data_mode ? slot_byte : 8'h00;
            if (data_mode && slot < SLOT_W'(NUM_AD)) slot <= slot + SLOT_W'(1);
          end else begin
            tx <= tx >> 1;
          end
        end
      end
    end
  end

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
  a_r6_we_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> byte_done);
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (ram_addr == $past(ram_addr) + ADDR_W'(1)) || !act);
  a_r4_filter_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ck_f) |-> $past(tick) && (ck_f == $past(ck_prev)));
  a_r2_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdout_oe);
endmodule

// File: tb/serial_cmd_dec_tb_top.sv
`timescale 1ns/1ps
module serial_cmd_dec_tb_top;
  localparam int HALF = 40;
  localparam int NAD  = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic [NAD*8-1:0] ad_bytes;
  logic sdout, sdout_oe, byte_done, ram_we, disp_on, seg_wide;
  logic [5:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [1:0] digit_cnt, duty_sel;
  logic [3:0] dig_start, port_lo, port_hi;

  always #4 clk = ~clk;

  serial_cmd_dec dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .ad_bytes(ad_bytes), .sdout(sdout), .sdout_oe(sdout_oe),
    .byte_done(byte_done), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .disp_on(disp_on), .digit_cnt(digit_cnt),
    .duty_sel(duty_sel), .dig_start(dig_start), .seg_wide(seg_wide),
    .port_lo(port_lo), .port_hi(port_hi));

  int n_chk = 0, n_bad = 0, n_wr = 0, n_stb = 0;
  logic [7:0] mem [64];
  bit finished = 1'b0;

  always @(posedge clk) begin
    if (ram_we) begin mem[ram_addr] <= ram_wdata; n_wr <= n_wr + 1; end
    if (byte_done) n_stb <= n_stb + 1;
  end

  function automatic logic [7:0] ad_val(int k);
    return 8'h81 + 8'(k * 8'h12);
  endfunction

  function automatic logic [17:0] cfg();
    return {disp_on, digit_cnt, duty_sel, dig_start, seg_wide, port_lo, port_hi};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdin = b[i];
      wait_clk(HALF);
      got[i] = sdout;
      sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic open_frame();
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic close_frame();
    wait_clk(HALF); cs_n = 1'b1; wait_clk(2 * HALF);
  endtask

  // {command, expected config after it}: {disp_on,digit_cnt,duty_sel,dig_start,seg_wide,port_lo,port_hi}
  localparam logic [25:0] VEC [7] = '{
    {8'hD6, 1'b1, 2'b01, 2'b10, 4'h0, 1'b0, 4'h0, 4'h0},
    {8'hA9, 1'b1, 2'b01, 2'b10, 4'h9, 1'b0, 4'h0, 4'h0},
    {8'h85, 1'b1, 2'b01, 2'b10, 4'h9, 1'b0, 4'h5, 4'h0},
    {8'h9C, 1'b1, 2'b01, 2'b10, 4'h9, 1'b0, 4'h5, 4'hC},
    {8'h4F, 1'b1, 2'b01, 2'b10, 4'h9, 1'b0, 4'h5, 4'hC},
    {8'hC3, 1'b0, 2'b00, 2'b11, 4'h9, 1'b0, 4'h5, 4'hC},
    {8'hE1, 1'b0, 2'b00, 2'b11, 4'h9, 1'b1, 4'h5, 4'hC}
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual %h expected %h", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] got;
    for (int k = 0; k < NAD; k++) ad_bytes[k*8 +: 8] = ad_val(k);
    wait_clk(5);
    check("R9 cfg after reset", 32'(cfg()), 0);
    check("R9 ram_we after reset", 32'(ram_we), 0);
    check("R2 oe with cs high", 32'(sdout_oe), 0);
    rst_n = 1'b1;
    wait_clk(10);

    for (int v = 0; v < 7; v++) begin
      open_frame();
      send_byte(VEC[v][25:18], got);
      close_frame();
      check((v == 4) ? "R10 ignored cmd" : "R5 cmd decode", 32'(cfg()), 32'(VEC[v][17:0]));
    end

    // display data frame: command, then 8 data bytes
    n_wr = 0; n_stb = 0;
    open_frame();
    check("R2 oe with cs low", 32'(sdout_oe), 1);
    send_byte(8'hE0, got);
    check("R7 command slot output", 32'(got), 0);
    for (int k = 0; k < 8; k++) begin
      send_byte(8'h30 + 8'(k * 7), got);
      check("R7 converter slot", 32'(got), (k < NAD) ? 32'(ad_val(k)) : 0);
    end
    close_frame();
    check("R2 oe released", 32'(sdout_oe), 0);
    check("R5 seg_wide cleared", 32'(seg_wide), 0);
    check("R6 write count", n_wr, 8);
    check("R8 strobe count", n_stb, 9);
    for (int k = 0; k < 8; k++)
      check("R6 ram content", 32'(mem[k]), 32'(8'h30 + 8'(k * 7)));

    // new frame restarts at address 0
    n_wr = 0;
    open_frame();
    send_byte(8'hE1, got);
    send_byte(8'h5A, got);
    close_frame();
    check("R1 address restart", 32'(mem[0]), 32'h5A);
    check("R1 single write", n_wr, 1);
    check("R3 seg_wide set", 32'(seg_wide), 1);

    // partial byte discarded
    n_stb = 0;
    open_frame();
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; sdin = 1'b1; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF);
    end
    close_frame();
    check("R1 no strobe on partial", n_stb, 0);
    open_frame();
    send_byte(8'h87, got);
    close_frame();
    check("R1 partial discarded", 32'(port_lo), 32'h7);
    check("R3 lsb first", 32'(port_hi), 32'hC);

    // glitches on clock and data are rejected
    n_stb = 0;
    open_frame();
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdin = 8'h9A >> i;
      wait_clk(HALF / 2);
      if (i == 2) begin sdin = ~sdin; wait_clk(1); sdin = ~sdin; end
      wait_clk(HALF / 2);
      sclk = 1'b1;
      wait_clk(HALF / 2);
      if (i == 3) begin sclk = 1'b0; wait_clk(1); sclk = 1'b1; end
      wait_clk(HALF / 2);
    end
    close_frame();
    check("R4 glitch rejected", 32'(port_hi), 32'hA);
    check("R4 one byte only", n_stb, 1);

    finish_run();
  end
endmodule